// File: doc/BRIEF.md
# Coalescing Store Buffer

This block is a short queue of pending writes that sits in front of a data array protected by word-granular ECC. Every entry holds one aligned word address, a data word and a byte-lane mask. When a narrow store arrives for the same aligned word as the newest waiting entry, its bytes are folded into that entry and no new slot is used. Entries leave in the order they were created. Each entry is sent out with a flag that says whether it covers the whole word. When the flag is set, the array can write the word directly. When it is clear, the array has to read the word, merge the new bytes and regenerate the check bits.

Stores come in on a valid/ready port, and writes go to the array on a second valid/ready port. A merge is allowed only into the newest entry, and only while that entry is not being offered downstream. This rule keeps the order in which words reach the array the same as program order. Each new head entry waits one cycle before it is offered, which gives a following store to the same word a chance to join it. An entry that is already full is offered at once.

Top module: `store_coalesce_buf`

## Requirements
- R1: After reset the buffer is empty, `cm_valid` is 0 and `st_ready` is 1.
- R2: A store to the same word address as the newest uncommitted entry merges into it. The single resulting commit carries the OR of both byte masks.
- R3: When a merge writes byte lanes that are already set, the newer store's bytes replace the older ones. Lanes that no store has written read as zero in `cm_data`.
- R4: A store to a word address that differs from the newest entry takes a new entry. Commits leave in the order in which entries were created.
- R5: A merge is checked against the newest entry only. For stores to words A, B, A, the result is three commits in the order A, B, A.
- R6: Once the head entry is offered (`cm_valid` is 1) and it is also the only entry, a new store to its word allocates a new entry and does not merge.
- R7: A head entry whose mask is partial raises `cm_valid` no earlier than the second cycle after the store that created it was accepted.
- R8: `cm_full` is 1 exactly when all four mask bits are set. An entry created with a full mask is offered in the first cycle after it is accepted.
- R9: With four entries held, `st_ready` is 0 unless the store would merge into the newest entry. A merging store is still accepted in that state.
- R10: A store whose byte mask is zero is accepted in any state and changes nothing. No commit ever carries an empty mask.
- R11: While `cm_valid` is 1 and `cm_ready` is 0, the values on `cm_addr`, `cm_data` and `cm_mask` stay unchanged.
- R12: Mask bit i selects data bits [8i+7:8i] on both the store port and the commit port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store is presented |
| st_ready | output | 1 | The buffer accepts the presented store |
| st_addr | input | WADDR_W | Aligned word address of the store |
| st_data | input | DATA_W | Store data, placed in its byte lanes |
| st_be | input | DATA_W/8 | Byte-lane enables of the store |
| cm_valid | output | 1 | The head entry is offered to the array |
| cm_ready | input | 1 | The array takes the offered entry |
| cm_addr | output | WADDR_W | Word address of the head entry |
| cm_data | output | DATA_W | Merged data of the head entry |
| cm_mask | output | DATA_W/8 | Byte lanes covered by the head entry |
| cm_full | output | 1 | All lanes covered, so the array can skip its read-modify-write |

## Verification
The bench uses the default parameters: a depth of four entries, 32-bit data with four byte lanes, and a 30-bit word address. Random addresses come from a pool of only four words, and `cm_ready` is often held low. Together these keep the newest-entry comparison busy and fill the buffer regularly, so merges while full, merges blocked by an offered head, and allocations that wrap the pointers all occur many times. Zero-mask stores and fully covered stores are mixed into the random traffic so that the drop path and the immediate-offer path are exercised alongside ordinary partial stores.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    ADM_IDLE  = 2'd0,
    ADM_MERGE = 2'd1,
    ADM_ALLOC = 2'd2,
    ADM_DROP  = 2'd3
  } adm_e;
endpackage

// File: rtl/scb_ptr_ctrl.sv
module scb_ptr_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head_idx,
  output logic [PTR_W-1:0] tail_idx,
  output logic [PTR_W-1:0] young_idx,
  output logic [CNT_W-1:0] count
);
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
  endfunction

  assign young_idx = ptr_prev(tail_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_idx <= '0;
      tail_idx <= '0;
      count    <= '0;
    end else begin
      if (push) tail_idx <= ptr_next(tail_idx);
      if (pop)  head_idx <= ptr_next(head_idx);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH)));
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/scb_entry_store.sv
module scb_entry_store #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned WADDR_W = 30,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned LANES  = DATA_W / scb_pkg::LANE_W,
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [PTR_W-1:0]   alloc_idx,
  input  logic [WADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0]  alloc_data,
  input  logic [LANES-1:0]   alloc_be,
  input  logic               merge_en,
  input  logic [PTR_W-1:0]   merge_idx,
  input  logic [DATA_W-1:0]  merge_data,
  input  logic [LANES-1:0]   merge_be,
  input  logic               pop_en,
  input  logic [PTR_W-1:0]   head_idx,
  input  logic [PTR_W-1:0]   young_idx,
  output logic [WADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0]  head_data,
  output logic [LANES-1:0]   head_mask,
  output logic               head_aged,
  output logic [WADDR_W-1:0] young_addr,
  output logic [DEPTH-1:0]   valid_vec
);
  localparam int unsigned LW = scb_pkg::LANE_W;

  // Lane-wise overlay: lanes enabled in be come from nw, others from old.
  function automatic logic [DATA_W-1:0] overlay_lanes(
    input logic [DATA_W-1:0] old,
    input logic [DATA_W-1:0] nw,
    input logic [LANES-1:0]  be
  );
    logic [DATA_W-1:0] r;
    r = old;
    for (int b = 0; b < LANES; b++) begin
      if (be[b]) r[b*LW +: LW] = nw[b*LW +: LW];
    end
    return r;
  endfunction

  logic [WADDR_W-1:0] e_addr  [DEPTH];
  logic [DATA_W-1:0]  e_data  [DEPTH];
  logic [LANES-1:0]   e_mask  [DEPTH];
  logic               e_valid [DEPTH];
  logic               e_aged  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic alloc_here, merge_here, pop_here;
    assign alloc_here = alloc_en && (alloc_idx == PTR_W'(i));
    assign merge_here = merge_en && (merge_idx == PTR_W'(i));
    assign pop_here   = pop_en   && (head_idx  == PTR_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_addr[i]  <= '0;
        e_data[i]  <= '0;
        e_mask[i]  <= '0;
        e_valid[i] <= 1'b0;
        e_aged[i]  <= 1'b0;
      end else if (alloc_here) begin
        e_addr[i]  <= alloc_addr;
        e_data[i]  <= overlay_lanes('0, alloc_data, alloc_be);
        e_mask[i]  <= alloc_be;
        e_valid[i] <= 1'b1;
        e_aged[i]  <= 1'b0;
      end else begin
        if (merge_here) begin
          e_data[i] <= overlay_lanes(e_data[i], merge_data, merge_be);
          e_mask[i] <= e_mask[i] | merge_be;
        end
        if (pop_here) begin
          e_valid[i] <= 1'b0;
          e_aged[i]  <= 1'b0;
        end else if (e_valid[i]) begin
          e_aged[i] <= 1'b1;
        end
      end
    end

    a_r10_merge_live: assert property (@(posedge clk) disable iff (!rst_n)
      merge_here |-> e_valid[i]);
    a_r4_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_here |-> !e_valid[i]);
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) valid_vec[k] = e_valid[k];
  end

  assign head_addr  = e_addr[head_idx];
  assign head_data  = e_data[head_idx];
  assign head_mask  = e_mask[head_idx];
  assign head_aged  = e_aged[head_idx];
  assign young_addr = e_addr[young_idx];
endmodule

// File: rtl/scb_admit.sv
module scb_admit #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned WADDR_W = 30,
  parameter int unsigned LANES   = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               st_valid,
  input  logic [WADDR_W-1:0] st_addr,
  input  logic [LANES-1:0]   st_be,
  input  logic [CNT_W-1:0]   count,
  input  logic [WADDR_W-1:0] young_addr,
  input  logic               young_offered,
  output logic               st_ready,
  output scb_pkg::adm_e      action
);
  import scb_pkg::*;

  logic young_hit, be_empty, has_room;

  assign young_hit = (count != '0) && (young_addr == st_addr) && !young_offered;
  assign be_empty  = (st_be == '0);
  assign has_room  = (count < CNT_W'(DEPTH));
  assign st_ready  = be_empty || young_hit || has_room;

  always_comb begin
    action = ADM_IDLE;
    if (st_valid) begin
      if (be_empty)       action = ADM_DROP;
      else if (young_hit) action = ADM_MERGE;
      else if (has_room)  action = ADM_ALLOC;
    end
  end
endmodule

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned WADDR_W = 30,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned LANES  = DATA_W / scb_pkg::LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_valid,
  output logic               st_ready,
  input  logic [WADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0]  st_data,
  input  logic [LANES-1:0]   st_be,
  output logic               cm_valid,
  input  logic               cm_ready,
  output logic [WADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0]  cm_data,
  output logic [LANES-1:0]   cm_mask,
  output logic               cm_full
);
  import scb_pkg::*;

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]   head_idx, tail_idx, young_idx;
  logic [CNT_W-1:0]   count;
  logic [WADDR_W-1:0] young_addr;
  logic               head_aged;
  logic [DEPTH-1:0]   valid_vec;
  adm_e               action;

  // Named internal events for the checks below.
  logic ev_push, ev_merge, ev_pop, ev_young_offered, ev_head_eligible;

  scb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .pop(ev_pop),
    .head_idx(head_idx), .tail_idx(tail_idx), .young_idx(young_idx),
    .count(count)
  );

  scb_entry_store #(.DEPTH(DEPTH), .WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(ev_push), .alloc_idx(tail_idx), .alloc_addr(st_addr),
    .alloc_data(st_data), .alloc_be(st_be),
    .merge_en(ev_merge), .merge_idx(young_idx), .merge_data(st_data),
    .merge_be(st_be),
    .pop_en(ev_pop), .head_idx(head_idx), .young_idx(young_idx),
    .head_addr(cm_addr), .head_data(cm_data), .head_mask(cm_mask),
    .head_aged(head_aged), .young_addr(young_addr), .valid_vec(valid_vec)
  );

  scb_admit #(.DEPTH(DEPTH), .WADDR_W(WADDR_W), .LANES(LANES)) u_admit (
    .st_valid(st_valid), .st_addr(st_addr), .st_be(st_be), .count(count),
    .young_addr(young_addr), .young_offered(ev_young_offered),
    .st_ready(st_ready), .action(action)
  );

  assign cm_full          = &cm_mask;
  assign ev_head_eligible = (count != '0) && (head_aged || cm_full);
  assign cm_valid         = ev_head_eligible;
  assign ev_young_offered = cm_valid && (count == CNT_W'(1));
  assign ev_push          = (action == ADM_ALLOC);
  assign ev_merge         = (action == ADM_MERGE);
  assign ev_pop           = cm_valid && cm_ready;

  a_r11_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_addr) &&
                                 $stable(cm_data) && $stable(cm_mask)));
  a_r10_no_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (cm_mask != '0));
  a_r4_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'($countones(valid_vec)) == count);
  a_r6_offered_no_merge: assert property (@(posedge clk) disable iff (!rst_n)
    ev_young_offered |-> !ev_merge);
  a_r7_partial_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && count == '0 && !(&st_be)) |=> !cm_valid);
endmodule

// File: tb/store_coalesce_buf_tb.sv
module store_coalesce_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, st_ready, cm_valid, cm_ready, cm_full;
  logic [29:0] st_addr, cm_addr;
  logic [31:0] st_data, cm_data;
  logic [3:0]  st_be, cm_mask;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  store_coalesce_buf u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr),
    .cm_data(cm_data), .cm_mask(cm_mask), .cm_full(cm_full)
  );

  // Reference queue, index 0 is the oldest entry.
  logic [29:0] m_addr [4];
  logic [31:0] m_data [4];
  logic [3:0]  m_mask [4];
  logic        m_age  [4];
  int          m_cnt;

  // Last observed outputs.
  logic        o_rdy, o_cv, o_full;
  logic [29:0] o_addr;
  logic [31:0] o_data;
  logic [3:0]  o_mask;

  function automatic logic [31:0] put_bytes(input logic [31:0] base,
                                            input logic [31:0] nw,
                                            input logic [3:0] be);
    logic [31:0] sel;
    for (int b = 0; b < 4; b++) sel[b*8 +: 8] = {8{be[b]}};
    return (base & ~sel) | (nw & sel);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [29:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic rdy);
    logic e_cv, e_hit, e_rdy, fire, pop;
    @(negedge clk);
    st_valid = v; st_addr = a; st_data = d; st_be = be; cm_ready = rdy;
    #1;
    e_cv  = (m_cnt > 0) && (m_age[0] || m_mask[0] == 4'hF);
    e_hit = (m_cnt > 0) && (m_addr[m_cnt-1] == a) && !(m_cnt == 1 && e_cv);
    e_rdy = (be == 4'h0) || e_hit || (m_cnt < 4);
    o_rdy = st_ready; o_cv = cm_valid; o_addr = cm_addr; o_data = cm_data;
    o_mask = cm_mask; o_full = cm_full;
    check(st_ready === e_rdy, "R9", "st_ready", 32'(st_ready), 32'(e_rdy));
    check(cm_valid === e_cv, "R7", "cm_valid", 32'(cm_valid), 32'(e_cv));
    if (e_cv) begin
      check(cm_addr === m_addr[0], "R4", "cm_addr", 32'(cm_addr), 32'(m_addr[0]));
      check(cm_data === m_data[0], "R3", "cm_data", cm_data, m_data[0]);
      check(cm_mask === m_mask[0], "R2", "cm_mask", 32'(cm_mask), 32'(m_mask[0]));
      check(cm_full === (m_mask[0] == 4'hF), "R8", "cm_full", 32'(cm_full),
            32'(m_mask[0] == 4'hF));
    end
    fire = v && e_rdy && (be != 4'h0);
    pop  = e_cv && rdy;
    for (int i = 0; i < m_cnt; i++) m_age[i] = 1'b1;
    if (fire && e_hit) begin
      m_data[m_cnt-1] = put_bytes(m_data[m_cnt-1], d, be);
      m_mask[m_cnt-1] = m_mask[m_cnt-1] | be;
    end
    if (pop) begin
      for (int i = 0; i < 3; i++) begin
        m_addr[i] = m_addr[i+1]; m_data[i] = m_data[i+1];
        m_mask[i] = m_mask[i+1]; m_age[i] = m_age[i+1];
      end
      m_cnt--;
    end
    if (fire && !e_hit) begin
      m_addr[m_cnt] = a; m_data[m_cnt] = put_bytes(32'h0, d, be);
      m_mask[m_cnt] = be; m_age[m_cnt] = 1'b0;
      m_cnt++;
    end
    @(posedge clk);
  endtask

  task automatic idle(input logic rdy);
    step(1'b0, 30'h0, 32'h0, 4'h0, rdy);
  endtask

  // Drain with ready high, record commit addresses.
  logic [29:0] seen [8];
  int          n_seen;
  task automatic drain();
    n_seen = 0;
    for (int k = 0; k < 12; k++) begin
      idle(1'b1);
      if (o_cv && n_seen < 8) begin seen[n_seen] = o_addr; n_seen++; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
    cm_ready = 1'b0; m_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = '0; m_data[i] = '0; m_mask[i] = '0; m_age[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check(cm_valid === 1'b0, "R1", "cm_valid", 32'(cm_valid), 32'h0);
    check(st_ready === 1'b1, "R1", "st_ready", 32'(st_ready), 32'h1);

    // R2 / R12: two byte stores merge into lanes 0 and 1
    step(1'b1, 30'h5, 32'h0000_00AA, 4'b0001, 1'b0);
    step(1'b1, 30'h5, 32'h0000_BB00, 4'b0010, 1'b0);
    idle(1'b0);
    check(o_mask === 4'b0011, "R2", "merged mask", 32'(o_mask), 32'h3);
    check(o_data === 32'h0000_BBAA, "R12", "lane data", o_data, 32'h0000_BBAA);
    // R11 hold while stalled
    idle(1'b0);
    check(o_cv && o_data === 32'h0000_BBAA, "R11", "held data", o_data, 32'h0000_BBAA);
    drain();
    check(n_seen == 1, "R2", "commit count", 32'(n_seen), 32'd1);

    // R3 overlap: newer bytes win
    step(1'b1, 30'h9, 32'h0000_1111, 4'b0011, 1'b0);
    step(1'b1, 30'h9, 32'h2222_2200, 4'b0110, 1'b0);
    idle(1'b0);
    check(o_data === 32'h0022_2211, "R3", "overlap data", o_data, 32'h0022_2211);
    drain();

    // R7: partial head waits one extra cycle
    step(1'b1, 30'h7, 32'h0000_0001, 4'b0001, 1'b0);
    idle(1'b0);
    check(o_cv === 1'b0, "R7", "early offer", 32'(o_cv), 32'h0);
    idle(1'b0);
    check(o_cv === 1'b1, "R7", "late offer", 32'(o_cv), 32'h1);
    drain();

    // R8: full store offered at once with the full flag
    step(1'b1, 30'h3, 32'hDEAD_BEEF, 4'hF, 1'b0);
    idle(1'b0);
    check(o_cv && o_full, "R8", "full offer", {o_cv, o_full}, 32'h3);
    drain();

    // R5: A, B, A gives three ordered commits
    step(1'b1, 30'hA, 32'h1, 4'b0001, 1'b0);
    step(1'b1, 30'hB, 32'h2, 4'b0001, 1'b0);
    step(1'b1, 30'hA, 32'h300, 4'b0010, 1'b0);
    drain();
    check(n_seen == 3 && seen[0] == 30'hA && seen[1] == 30'hB && seen[2] == 30'hA,
          "R5", "order", 32'(n_seen), 32'd3);

    // R6: offered single head does not merge
    step(1'b1, 30'hC, 32'h1, 4'b0001, 1'b0);
    idle(1'b0); idle(1'b0);
    step(1'b1, 30'hC, 32'h200, 4'b0010, 1'b0);
    drain();
    check(n_seen == 2, "R6", "commits", 32'(n_seen), 32'd2);

    // R9 / R10: full buffer
    for (int k = 0; k < 4; k++) step(1'b1, 30'(16 + k), 32'h5, 4'b0001, 1'b0);
    step(1'b1, 30'h30, 32'h5, 4'b0001, 1'b0);
    check(o_rdy === 1'b0, "R9", "full ready", 32'(o_rdy), 32'h0);
    step(1'b1, 30'd19, 32'h0600, 4'b0010, 1'b0);
    check(o_rdy === 1'b1, "R9", "merge when full", 32'(o_rdy), 32'h1);
    step(1'b1, 30'h31, 32'h7, 4'b0000, 1'b0);
    check(o_rdy === 1'b1, "R10", "empty mask ready", 32'(o_rdy), 32'h1);
    drain();
    check(n_seen == 4, "R10", "commits after drop", 32'(n_seen), 32'd4);

    // Random traffic against the reference queue
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] be;
      int sel;
      sel = $urandom_range(0, 9);
      be  = (sel == 0) ? 4'h0 : (sel == 1) ? 4'hF : 4'($urandom_range(1, 15));
      step($urandom_range(0, 3) != 0, 30'($urandom_range(0, 3)), $urandom, be,
           $urandom_range(0, 9) < 4);
    end
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule